// File: doc/BRIEF.md
# DDR Command Decoder and Timing Checker

This block watches the command and address pins of a double-data-rate SDRAM channel and samples them on every rising clock edge. It turns the strobe pattern into a command code, keeps an open/idle flag for each of four banks, follows the read or write burst in flight, and compares the spacing between commands against minimum and maximum cycle counts for a 5 ns clock. The counts are parameters. It only observes. Every command takes effect in the tracked state whether or not it breaks a rule.

Each timing or protocol rule has its own bit in a violation vector. A bit sets one cycle after the offending edge and stays set until software-free logic pulses `viol_clr`. The decoded command and the bank flags are registered, so they also appear one cycle after the edge that produced them. The block has no streaming data path. All pins are plain level signals and there is no handshake or back-pressure.

Distances are counted in edges. A rule of N cycles between A and B is met when B is sampled N or more edges after A.

Top module: `ddrmon_top`

## Requirements
- R1: With `cs_n` HIGH the command is DESELECT (code 0). Otherwise {`ras_n`,`cas_n`,`we_n`} decodes as follows: 111 NOP (1), 011 ACTIVE (2), 101 READ (3), 100 WRITE (4), 110 BURST STOP (5), 010 PRECHARGE (6), 000 MODE LOAD (9). `cmd_o` shows the code one cycle after the edge.
- R2: Pattern 001 decodes as AUTO REFRESH (7) when `cke` is HIGH and as SELF REFRESH entry (8) when `cke` is LOW.
- R3: ACTIVE sets `bank_open_o[ba]`. PRECHARGE with `addr[10]` LOW clears only `bank_open_o[ba]`. PRECHARGE with `addr[10]` HIGH clears all four bits and ignores `ba`.
- R4: READ or WRITE with `addr[10]` HIGH closes its bank automatically. The bank is sampled at edge n, the burst lasts BL/2 edges, and the bank flag clears after edge n+BL/2.
- R5: MODE LOAD with `ba`=0 sets the burst length from `addr[2:0]`: 001 gives 2, 010 gives 4, 011 gives 8. Other codes, and loads with `ba`≠0, keep the old value. The value after reset is 4.
- R6: Per-bank minimum spacings are flagged. READ/WRITE less than 4 after ACTIVE sets bit 0. ACTIVE less than 4 after that bank's precharge or auto-close sets bit 1. PRECHARGE of an open bank less than 8 after its ACTIVE sets bit 2. ACTIVE less than 12 after the same bank's ACTIVE sets bit 4.
- R7: A bank held open for more than 14000 edges since its ACTIVE sets bit 3.
- R8: ACTIVE less than 2 edges after any earlier ACTIVE sets bit 5.
- R9: Any command other than NOP or DESELECT sets bit 6 if it comes less than 14 after a refresh (auto or self). It sets bit 7 if it comes less than 2 after a MODE LOAD.
- R10: READ less than 2 edges after WRITE sets bit 8.
- R11: BURST STOP is legal only at edges n+1..n+BL/2 after a READ without auto-close at n. Anywhere else, including during writes and auto-close reads, it sets bit 9.
- R12: MODE LOAD while any bank is open or a burst is in progress sets bit 10.
- R13: READ/WRITE to an idle bank, or ACTIVE to an open bank, sets bit 11.
- R14: Violation bits are sticky. `viol_clr` clears them at the next edge, but a violation at that same edge stays set. Commands are never blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge samples |
| rst_n | input | 1 | Asynchronous active-low reset |
| viol_clr | input | 1 | Clears sticky violation bits |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 12 | Address pins, bit 10 is the all/auto-close qualifier |
| cmd_o | output | 4 | Registered decoded command code |
| bank_open_o | output | 4 | Open flag per bank |
| viol_o | output | 12 | Sticky violation bits |

## Verification
The bound assertions check several properties on every cycle: deselect decoding, that no violation bit is lost without a clear, that a bank opens only together with an ACTIVE, and that back-to-back ACTIVEs, a mode load on an open bank and a read with no bank open always raise their flags. The exact spacing limits can only be shown by the bench's scenarios, which place commands one edge below and exactly at each limit. The same applies to the burst-length-dependent auto-close and stop windows, the 14000-cycle open limit and the interplay of a clear with a fresh violation. A seeded random stream of activates and precharges cross-checks bank tracking.

// File: rtl/ddrmon_pkg.sv
package ddrmon_pkg;
  typedef enum logic [3:0] {
    C_DESEL = 4'd0, C_NOP = 4'd1, C_ACT = 4'd2, C_RD = 4'd3, C_WR = 4'd4,
    C_BST = 4'd5, C_PRE = 4'd6, C_AREF = 4'd7, C_SREF = 4'd8, C_LMR = 4'd9
  } cmd_e;

  localparam int V_RCD    = 0;
  localparam int V_RP     = 1;
  localparam int V_RASMIN = 2;
  localparam int V_RASMAX = 3;
  localparam int V_RC     = 4;
  localparam int V_RRD    = 5;
  localparam int V_RFC    = 6;
  localparam int V_MRD    = 7;
  localparam int V_WTR    = 8;
  localparam int V_BST    = 9;
  localparam int V_MRS    = 10;
  localparam int V_PROTO  = 11;
  localparam int V_NUM    = 12;
endpackage

// File: rtl/ddrmon_decode.sv
module ddrmon_decode
  import ddrmon_pkg::*;
(
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    if (cs_n) begin
      cmd = C_DESEL;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b111:  cmd = C_NOP;
        3'b011:  cmd = C_ACT;
        3'b101:  cmd = C_RD;
        3'b100:  cmd = C_WR;
        3'b110:  cmd = C_BST;
        3'b010:  cmd = C_PRE;
        3'b001:  cmd = cke ? C_AREF : C_SREF;
        default: cmd = C_LMR;
      endcase
    end
  end
endmodule

// File: rtl/ddrmon_age.sv
module ddrmon_age #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt,
  output logic [W-1:0] age
);
  // Edges since the last event; saturates, starts saturated (no history).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age <= '1;
    else if (evt)            age <= W'(1);
    else if (age != '1)      age <= age + W'(1);
  end
endmodule

// File: rtl/ddrmon_bank.sv
module ddrmon_bank #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         act_hit,
  input  logic         close_hit,
  output logic         is_open,
  output logic [W-1:0] act_age,
  output logic [W-1:0] pre_age
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         is_open <= 1'b0;
    else if (act_hit)   is_open <= 1'b1;
    else if (close_hit) is_open <= 1'b0;
  end

  ddrmon_age #(.W(W)) act_ctr_i (.clk(clk), .rst_n(rst_n), .evt(act_hit),   .age(act_age));
  ddrmon_age #(.W(W)) pre_ctr_i (.clk(clk), .rst_n(rst_n), .evt(close_hit), .age(pre_age));
endmodule

// File: rtl/ddrmon_top.sv
module ddrmon_top
  import ddrmon_pkg::*;
#(
  parameter int NBANK    = 4,
  parameter int ADDR_W   = 12,
  parameter int AP_BIT   = 10,
  parameter int TRCD     = 4,
  parameter int TRP      = 4,
  parameter int TRAS_MIN = 8,
  parameter int TRAS_MAX = 14000,
  parameter int TRC      = 12,
  parameter int TRRD     = 2,
  parameter int TRFC     = 14,
  parameter int TMRD     = 2,
  parameter int TWTR     = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       viol_clr,
  input  logic                       cke,
  input  logic                       cs_n,
  input  logic                       ras_n,
  input  logic                       cas_n,
  input  logic                       we_n,
  input  logic [$clog2(NBANK)-1:0]   ba,
  input  logic [ADDR_W-1:0]          addr,
  output logic [3:0]                 cmd_o,
  output logic [NBANK-1:0]           bank_open_o,
  output logic [V_NUM-1:0]           viol_o
);
  localparam int BA_W = $clog2(NBANK);
  localparam int W    = $clog2(TRAS_MAX + 2);
  localparam logic [W-1:0] TRCD_C  = W'(TRCD);
  localparam logic [W-1:0] TRP_C   = W'(TRP);
  localparam logic [W-1:0] TRASN_C = W'(TRAS_MIN);
  localparam logic [W-1:0] TRASX_C = W'(TRAS_MAX);
  localparam logic [W-1:0] TRC_C   = W'(TRC);
  localparam logic [W-1:0] TRRD_C  = W'(TRRD);
  localparam logic [W-1:0] TRFC_C  = W'(TRFC);
  localparam logic [W-1:0] TMRD_C  = W'(TMRD);
  localparam logic [W-1:0] TWTR_C  = W'(TWTR);

  cmd_e cmd, cmd_q;
  logic is_act, is_rd, is_wr, is_bst, is_pre, is_ref, is_lmr, busy;
  logic [NBANK-1:0] bsel, act_hit, pre_hit, ap_close, act_short, act_long, bank_open;
  logic [W-1:0] act_age [NBANK];
  logic [W-1:0] pre_age [NBANK];
  logic [W-1:0] gact_age, gref_age, glmr_age, gwr_age;
  logic [2:0] bl_half, burst_left;
  logic burst_rd_plain, burst_ap, burst_last;
  logic [BA_W-1:0] burst_bank;
  logic [V_NUM-1:0] viol_now, viol_q;
  logic unused_addr_bits;

  assign unused_addr_bits = ^{addr[ADDR_W-1:AP_BIT+1], addr[AP_BIT-1:3]};

  ddrmon_decode dec_i (
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  assign is_act = (cmd == C_ACT);
  assign is_rd  = (cmd == C_RD);
  assign is_wr  = (cmd == C_WR);
  assign is_bst = (cmd == C_BST);
  assign is_pre = (cmd == C_PRE);
  assign is_ref = (cmd == C_AREF) || (cmd == C_SREF);
  assign is_lmr = (cmd == C_LMR);
  assign busy   = (cmd != C_DESEL) && (cmd != C_NOP);
  assign burst_last = (burst_left == 3'd1);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bsel[b]      = (ba == BA_W'(b));
    assign act_hit[b]   = is_act & bsel[b];
    assign pre_hit[b]   = is_pre & (addr[AP_BIT] | bsel[b]);
    assign ap_close[b]  = burst_last & burst_ap & (burst_bank == BA_W'(b));
    assign act_short[b] = act_age[b] < TRASN_C;
    assign act_long[b]  = act_age[b] > TRASX_C;

    ddrmon_bank #(.W(W)) bank_i (
      .clk(clk), .rst_n(rst_n),
      .act_hit(act_hit[b]), .close_hit(pre_hit[b] | ap_close[b]),
      .is_open(bank_open[b]), .act_age(act_age[b]), .pre_age(pre_age[b])
    );
  end

  ddrmon_age #(.W(W)) gact_i (.clk(clk), .rst_n(rst_n), .evt(is_act), .age(gact_age));
  ddrmon_age #(.W(W)) gref_i (.clk(clk), .rst_n(rst_n), .evt(is_ref), .age(gref_age));
  ddrmon_age #(.W(W)) glmr_i (.clk(clk), .rst_n(rst_n), .evt(is_lmr), .age(glmr_age));
  ddrmon_age #(.W(W)) gwr_i  (.clk(clk), .rst_n(rst_n), .evt(is_wr),  .age(gwr_age));

  // Burst tracking and burst length from mode load
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst_left     <= '0;
      burst_rd_plain <= 1'b0;
      burst_ap       <= 1'b0;
      burst_bank     <= '0;
      bl_half        <= 3'd2;
    end else begin
      if (is_rd || is_wr) begin
        burst_left     <= bl_half;
        burst_rd_plain <= is_rd & ~addr[AP_BIT];
        burst_ap       <= addr[AP_BIT];
        burst_bank     <= ba;
      end else if (is_bst) begin
        burst_left <= '0;
      end else if (burst_left != '0) begin
        burst_left <= burst_left - 3'd1;
      end
      if (is_lmr && ba == '0) begin
        case (addr[2:0])
          3'b001:  bl_half <= 3'd1;
          3'b010:  bl_half <= 3'd2;
          3'b011:  bl_half <= 3'd4;
          default: bl_half <= bl_half;
        endcase
      end
    end
  end

  always_comb begin
    viol_now           = '0;
    viol_now[V_RCD]    = (is_rd | is_wr) & bank_open[ba] & (act_age[ba] < TRCD_C);
    viol_now[V_RP]     = is_act & (pre_age[ba] < TRP_C);
    viol_now[V_RASMIN] = |(pre_hit & bank_open & act_short);
    viol_now[V_RASMAX] = |(bank_open & act_long);
    viol_now[V_RC]     = is_act & (act_age[ba] < TRC_C);
    viol_now[V_RRD]    = is_act & (gact_age < TRRD_C);
    viol_now[V_RFC]    = busy & (gref_age < TRFC_C);
    viol_now[V_MRD]    = busy & (glmr_age < TMRD_C);
    viol_now[V_WTR]    = is_rd & (gwr_age < TWTR_C);
    viol_now[V_BST]    = is_bst & ~((burst_left != '0) & burst_rd_plain);
    viol_now[V_MRS]    = is_lmr & ((|bank_open) | (burst_left != '0));
    viol_now[V_PROTO]  = ((is_rd | is_wr) & ~bank_open[ba]) | (is_act & bank_open[ba]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= C_DESEL;
      viol_q <= '0;
    end else begin
      cmd_q  <= cmd;
      viol_q <= (viol_q & {V_NUM{~viol_clr}}) | viol_now;
    end
  end

  assign cmd_o       = cmd_q;
  assign bank_open_o = bank_open;
  assign viol_o      = viol_q;
endmodule

// File: rtl/ddrmon_chk.sv
module ddrmon_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        viol_clr,
  input logic        cs_n,
  input logic [3:0]  cmd_o,
  input logic [3:0]  bank_open_o,
  input logic [11:0] viol_o
);
  // R1
  desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (cmd_o == 4'd0));

  // R1
  cmd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_o <= 4'd9);

  // R14
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !viol_clr |=> ((viol_o & $past(viol_o)) == $past(viol_o)));

  // R3
  open_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bank_open_o & ~$past(bank_open_o)) != 4'd0) |-> (cmd_o == 4'd2));

  // R8
  rrd_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 4'd2 && $past(cmd_o) == 4'd2) |-> viol_o[5]);

  // R12
  lmr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 4'd9 && $past(bank_open_o) != 4'd0) |-> viol_o[10]);

  // R13
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == 4'd3 && $past(bank_open_o) == 4'd0) |-> viol_o[11]);
endmodule

bind ddrmon_top ddrmon_chk chk_i (
  .clk(clk), .rst_n(rst_n), .viol_clr(viol_clr), .cs_n(cs_n),
  .cmd_o(cmd_o), .bank_open_o(bank_open_o), .viol_o(viol_o)
);

// File: tb/ddrmon_top_tb_top.sv
`timescale 1ns/1ps
module ddrmon_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic viol_clr = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic [11:0] addr = '0;
  logic [3:0] cmd_o, bank_open_o;
  logic [11:0] viol_o;
  int n_chk = 0, n_fail = 0;

  localparam int NOP = 1, ACT = 2, RD = 3, WR = 4, BST = 5, PRE = 6, AREF = 7, SREF = 8, LMR = 9;
  localparam int A10 = 1 << 10;

  always #2 clk = ~clk;

  ddrmon_top dut_i (
    .clk(clk), .rst_n(rst_n), .viol_clr(viol_clr), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .cmd_o(cmd_o), .bank_open_o(bank_open_o), .viol_o(viol_o)
  );

  function automatic logic [3:0] pins_of(input int c);
    case (c)
      0: return 4'b1000;
      1: return 4'b0111;
      2: return 4'b0011;
      3: return 4'b0101;
      4: return 4'b0100;
      5: return 4'b0110;
      6: return 4'b0010;
      7, 8: return 4'b0001;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic step(input int c, input int bank, input int a, input bit clr);
    {cs_n, ras_n, cas_n, we_n} = pins_of(c);
    cke = (c == SREF) ? 1'b0 : 1'b1;
    ba = 2'(bank);
    addr = 12'(a);
    viol_clr = clr;
    @(posedge clk);
    @(negedge clk);
    viol_clr = 1'b0;
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) step(NOP, 0, 0, 1'b0);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    nop(20);
    step(NOP, 0, 0, 1'b1);
    chk("R14 clear", int'(viol_o), 0);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] mdl;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 reset cmd", int'(cmd_o), 0);
    chk("R3 reset banks", int'(bank_open_o), 0);
    chk("R14 reset flags", int'(viol_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 decode of every pattern
    step(0, 0, 0, 1'b0);     chk("R1 desel", int'(cmd_o), 0);
    step(NOP, 0, 0, 1'b0);   chk("R1 nop", int'(cmd_o), 1);
    step(ACT, 0, 0, 1'b0);   chk("R1 act", int'(cmd_o), 2);
    step(RD, 0, 0, 1'b0);    chk("R1 rd", int'(cmd_o), 3);
    step(WR, 0, 0, 1'b0);    chk("R1 wr", int'(cmd_o), 4);
    step(BST, 0, 0, 1'b0);   chk("R1 bst", int'(cmd_o), 5);
    step(PRE, 0, A10, 1'b0); chk("R1 pre", int'(cmd_o), 6);
    step(AREF, 0, 0, 1'b0);  chk("R2 aref", int'(cmd_o), 7);
    step(SREF, 0, 0, 1'b0);  chk("R2 sref", int'(cmd_o), 8);
    step(LMR, 0, 2, 1'b0);   chk("R1 lmr", int'(cmd_o), 9);
    clear_all();

    // R3 bank tracking
    step(ACT, 1, 0, 1'b0);  chk("R3 open b1", int'(bank_open_o), 4'b0010);
    nop(12);
    step(ACT, 2, 0, 1'b0);  chk("R3 open b2", int'(bank_open_o), 4'b0110);
    nop(12);
    step(PRE, 1, 0, 1'b0);  chk("R3 pre one", int'(bank_open_o), 4'b0100);
    nop(2);
    step(PRE, 3, A10, 1'b0); chk("R3 pre all", int'(bank_open_o), 4'b0000);
    chk("R6 no false flag", int'(viol_o), 0);
    nop(20);

    // R6 per-bank spacings
    step(ACT, 0, 0, 1'b0); nop(2);
    step(RD, 0, 0, 1'b0);  chk("R6 rcd short", int'(viol_o), 12'h001);
    clear_all();
    step(ACT, 3, 0, 1'b0); nop(3);
    step(WR, 3, 0, 1'b0);  chk("R6 rcd exact", int'(viol_o), 0);
    nop(3);
    step(PRE, 3, 0, 1'b0); chk("R6 ras exact", int'(viol_o), 0);
    nop(2);
    step(ACT, 3, 0, 1'b0); chk("R6 rp+rc short", int'(viol_o), 12'h012);
    step(NOP, 0, 0, 1'b1); chk("R14 clr", int'(viol_o), 0);
    nop(4);
    step(PRE, 3, 0, 1'b0); chk("R6 ras short", int'(viol_o), 12'h004);
    clear_all();
    step(ACT, 3, 0, 1'b0); nop(7);
    step(PRE, 3, 0, 1'b0); nop(3);
    step(ACT, 3, 0, 1'b0); chk("R6 rc/rp exact", int'(viol_o), 0);
    nop(8); step(PRE, 0, A10, 1'b0); nop(20);

    // R8 activate to activate
    step(ACT, 1, 0, 1'b0);
    step(ACT, 2, 0, 1'b0); chk("R8 rrd short", int'(viol_o), 12'h020);
    nop(1);
    step(ACT, 0, 0, 1'b0); chk("R8 rrd exact", int'(viol_o), 12'h020);
    nop(8); step(PRE, 0, A10, 1'b0);
    clear_all();

    // R9 refresh and mode-load spacing
    step(AREF, 0, 0, 1'b0); nop(12);
    step(ACT, 0, 0, 1'b0);  chk("R9 rfc short", int'(viol_o), 12'h040);
    nop(8); step(PRE, 0, 0, 1'b0);
    clear_all();
    step(AREF, 0, 0, 1'b0); nop(13);
    step(ACT, 0, 0, 1'b0);  chk("R9 rfc exact", int'(viol_o), 0);
    nop(8); step(PRE, 0, 0, 1'b0); nop(4);
    step(LMR, 0, 2, 1'b0);
    step(ACT, 1, 0, 1'b0);  chk("R9 mrd short", int'(viol_o), 12'h080);
    nop(8); step(PRE, 0, A10, 1'b0);
    clear_all();

    // R10 write to read
    step(ACT, 2, 0, 1'b0); nop(3);
    step(WR, 2, 0, 1'b0);
    step(RD, 2, 0, 1'b0);  chk("R10 wtr", int'(viol_o), 12'h100);
    nop(8); step(PRE, 0, A10, 1'b0);
    clear_all();

    // R11 burst stop window (burst length 4)
    step(ACT, 0, 0, 1'b0); nop(3);
    step(RD, 0, 0, 1'b0); step(BST, 0, 0, 1'b0);
    chk("R11 bst n+1", int'(viol_o), 0);
    step(RD, 0, 0, 1'b0); nop(1); step(BST, 0, 0, 1'b0);
    chk("R11 bst n+2", int'(viol_o), 0);
    step(RD, 0, 0, 1'b0); nop(2); step(BST, 0, 0, 1'b0);
    chk("R11 bst late", int'(viol_o), 12'h200);
    clear_all();
    step(WR, 0, 0, 1'b0); step(BST, 0, 0, 1'b0);
    chk("R11 bst write", int'(viol_o), 12'h200);
    clear_all();

    // R12 mode load with open bank
    step(LMR, 0, 2, 1'b0); chk("R12 lmr busy", int'(viol_o), 12'h400);
    nop(8); step(PRE, 0, A10, 1'b0);
    clear_all();

    // R13 R14 protocol and stickiness
    step(RD, 3, 0, 1'b0);  chk("R13 rd idle", int'(viol_o), 12'h800);
    nop(30);               chk("R14 sticky", int'(viol_o), 12'h800);
    step(RD, 3, 0, 1'b1);  chk("R14 clr vs new", int'(viol_o), 12'h800);
    chk("R14 not blocked", int'(cmd_o), 3);
    step(NOP, 0, 0, 1'b1); chk("R14 clr", int'(viol_o), 0);
    step(ACT, 3, 0, 1'b0); nop(11);
    step(ACT, 3, 0, 1'b0); chk("R13 act open", int'(viol_o), 12'h800);
    chk("R14 act taken", int'(cmd_o), 2);
    nop(8); step(PRE, 0, A10, 1'b0);
    clear_all();

    // R4 R5 auto-close timing per burst length
    step(LMR, 0, 3, 1'b0); nop(2);
    step(ACT, 1, 0, 1'b0); nop(3);
    step(RD, 1, A10, 1'b0); nop(3);
    chk("R4 bl8 still open", int'(bank_open_o[1]), 1);
    nop(1);
    chk("R4 bl8 closed", int'(bank_open_o[1]), 0);
    step(LMR, 1, 1, 1'b0); nop(6);
    step(ACT, 1, 0, 1'b0); nop(3);
    step(WR, 1, A10, 1'b0); nop(3);
    chk("R5 ext load keeps bl8", int'(bank_open_o[1]), 1);
    nop(1);
    chk("R4 wr auto close", int'(bank_open_o[1]), 0);
    nop(4);
    step(LMR, 0, 1, 1'b0); nop(2);
    step(ACT, 2, 0, 1'b0); nop(3);
    step(RD, 2, A10, 1'b0);
    chk("R4 bl2 open at n", int'(bank_open_o[2]), 1);
    nop(1);
    chk("R5 bl2 closed n+1", int'(bank_open_o[2]), 0);
    nop(4);
    step(LMR, 0, 7, 1'b0); nop(2);
    step(ACT, 2, 0, 1'b0); nop(3);
    step(RD, 2, A10, 1'b0); nop(1);
    chk("R5 reserved keeps bl2", int'(bank_open_o[2]), 0);
    chk("R4 no flags", int'(viol_o), 0);
    nop(20);

    // R7 maximum open time
    step(ACT, 0, 0, 1'b0);
    nop(14000);
    chk("R7 at limit", int'(viol_o[3]), 0);
    nop(1);
    chk("R7 over limit", int'(viol_o[3]), 1);
    step(PRE, 0, 0, 1'b0);
    clear_all();

    // R1 R3 seeded random activate/precharge stream
    mdl = '0;
    for (int i = 0; i < 400; i++) begin
      int pick, c, b, a;
      pick = int'($urandom % 4);
      c = (pick == 0) ? 0 : (pick == 1) ? NOP : (pick == 2) ? ACT : PRE;
      b = int'($urandom % 4);
      a = ($urandom % 2 == 1) ? A10 : 0;
      if (c == ACT) mdl[b] = 1'b1;
      else if (c == PRE) begin
        if (a != 0) mdl = '0;
        else mdl[b] = 1'b0;
      end
      step(c, b, a, 1'b0);
      chk("R1 rand cmd", int'(cmd_o), c);
      chk("R3 rand banks", int'(bank_open_o), int'(mdl));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule